// File: doc/BRIEF.md
# DMA Queue-Pair Channel Controller

This block holds the control and status registers of a multi-channel memory-to-memory DMA engine and runs one state machine per channel. Software reaches every channel through one 32-bit register bus. Each channel owns a window of 256 bytes. The window holds the submission and completion queue bases and depths, a submission tail doorbell, a completion head pointer, enable, pause and reset controls, a state readout, and interrupt status and mask. One global register selects endpoint or root-complex mode.

The data mover itself sits outside. For each channel the block raises `job_req_o` while that channel is running. The mover answers with a one-cycle `job_done_i` or `job_err_i` pulse. The controller then moves the internal submission head, sets interrupt status and drives one interrupt line per channel. Teardown follows a fixed order: software clears enable or sets pause, polls the state readout until it leaves RUN, pulses reset, and re-enables the channel, which then settles in IDLE.

Top module: `dmaq_ctrl`

## Requirements
- R1: The channel index is address bits [13:8], so channel windows sit 0x100 apart. Within a window the registers are: 0x00/0x04 submission base low/high, 0x08 submission depth, 0x0C submission tail, 0x10/0x14 completion base low/high, 0x18 completion depth, 0x1C completion head, 0x20 control 0, 0x24 control 1, 0x30 state, 0x40 interrupt status, 0x44 interrupt mask. Base registers keep all 32 bits. Depth and pointer registers keep 10 bits. After reset both depth registers read 0x3FF (entries minus one), the mask reads 0x1FFF, and every other register reads 0. Read data appears on `bus_rdata_o` one cycle after the read is sampled.
- R2: Reads of undefined offsets, or of channels at or above NUM_CH, return 0. Writes to them change no register.
- R3: Control 0 bit 0 is enable and bit 4 is pause. When enable is 1, pause is 0 and a doorbell write leaves the tail different from the internal head, the state goes from IDLE (code 0) to RUN (code 1) on the next edge. `job_req_o` is high exactly in RUN.
- R4: A `job_done_i` pulse in RUN gives CPL (code 2) on that edge and advances the internal head, wrapping to 0 after the value in the submission depth register. The next edge returns to IDLE, and the channel restarts only if the tail still differs from the head.
- R5: Setting pause in RUN gives PAUSE (code 3) on the next edge. Clearing pause returns to RUN.
- R6: Clearing enable in RUN or PAUSE gives HALT (code 4). Setting enable again with pause clear passes through WAIT (code 6) for one cycle and then to IDLE. The state never remains RUN one edge after enable is 0 or pause is 1.
- R7: A `job_err_i` pulse in RUN gives ABORT (code 5), which holds until reset.
- R8: Writing 1 to control 1 bit 0 is a self-clearing reset. On that edge the state becomes BUFFCLR (code 7), and the tail, internal head and completion head become 0. The next edge gives IDLE. Control 1 always reads 0.
- R9: Interrupt status is 13 bits. Bit 0 is set on entry to CPL and bit 1 on entry to ABORT. Writing 1 to a bit clears it.
- R10: `irq_o[c]` is high while any status bit of channel c is set with its mask bit at 0.
- R11: The global register at 0x217C bit 0 selects root-complex mode (1) or endpoint mode (0). It drives `mode_o` and reads back.
- R12: Channels are independent. Activity on one channel does not change another channel's state, pointers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read |
| mode_o | output | 1 | 1 = root-complex mode |
| irq_o | output | NUM_CH | Per-channel interrupt |
| job_req_o | output | NUM_CH | Channel in RUN, work for the mover |
| job_done_i | input | NUM_CH | Mover finished the current entry (pulse) |
| job_err_i | input | NUM_CH | Mover failed the current entry (pulse) |

## Verification
Each register write takes effect on the edge that samples it. A state transition caused by a control or doorbell write is visible one edge later. Read data returns the value held before the sampling edge, so the bench inserts one idle cycle after any write before it reads a state that the write caused. A done or error pulse changes the state on its own edge, so the one-cycle CPL state is captured by a read issued in the cycle right after the pulse. The direct outputs (`irq_o`, `job_req_o`, `mode_o`) are compared at the falling edge after the edge that changed them.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int DATA_W = 32;
  localparam int STS_W  = 13;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RUN     = 4'd1,
    ST_CPL     = 4'd2,
    ST_PAUSE   = 4'd3,
    ST_HALT    = 4'd4,
    ST_ABORT   = 4'd5,
    ST_WAIT    = 4'd6,
    ST_BUFFCLR = 4'd7
  } chan_state_e;

  localparam logic [7:0] OFF_SQ_LO   = 8'h00;
  localparam logic [7:0] OFF_SQ_HI   = 8'h04;
  localparam logic [7:0] OFF_SQ_LAST = 8'h08;
  localparam logic [7:0] OFF_SQ_TAIL = 8'h0C;
  localparam logic [7:0] OFF_CQ_LO   = 8'h10;
  localparam logic [7:0] OFF_CQ_HI   = 8'h14;
  localparam logic [7:0] OFF_CQ_LAST = 8'h18;
  localparam logic [7:0] OFF_CQ_HEAD = 8'h1C;
  localparam logic [7:0] OFF_CTL0    = 8'h20;
  localparam logic [7:0] OFF_CTL1    = 8'h24;
  localparam logic [7:0] OFF_STATE   = 8'h30;
  localparam logic [7:0] OFF_ISTS    = 8'h40;
  localparam logic [7:0] OFF_IMSK    = 8'h44;

  localparam logic [15:0] MODE_ADDR  = 16'h217C;
endpackage

// File: rtl/dmaq_addr_dec.sv
module dmaq_addr_dec #(
  parameter int ADDR_W = 14,
  parameter int NUM_CH = 4,
  localparam int CH_W  = ADDR_W - 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_idx_o,
  output logic [7:0]        off_o,
  output logic              ch_hit_o,
  output logic              mode_hit_o
);
  import dmaq_pkg::*;

  assign ch_idx_o   = addr_i[ADDR_W-1:8];
  assign off_o      = addr_i[7:0];
  assign ch_hit_o   = ({1'b0, ch_idx_o} < (CH_W+1)'(NUM_CH));
  assign mode_hit_o = (addr_i == ADDR_W'(MODE_ADDR));
endmodule

// File: rtl/dmaq_chan_fsm.sv
module dmaq_chan_fsm #(
  parameter int PTR_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 pause_i,
  input  logic                 soft_rst_i,
  input  logic [PTR_W-1:0]     sq_tail_i,
  input  logic [PTR_W-1:0]     sq_last_i,
  input  logic                 job_done_i,
  input  logic                 job_err_i,
  output dmaq_pkg::chan_state_e state_o,
  output logic                 job_req_o,
  output logic                 cpl_evt_o,
  output logic                 abort_evt_o
);
  import dmaq_pkg::*;

  chan_state_e state_q, state_d;
  logic [PTR_W-1:0] head_q;
  logic pending;

  assign pending = (sq_tail_i != head_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (en_i && !pause_i && pending) state_d = ST_RUN;
      ST_RUN: begin
        if (!en_i)          state_d = ST_HALT;
        else if (pause_i)   state_d = ST_PAUSE;
        else if (job_err_i) state_d = ST_ABORT;
        else if (job_done_i) state_d = ST_CPL;
      end
      ST_CPL:     state_d = ST_IDLE;
      ST_PAUSE: begin
        if (!en_i)        state_d = ST_HALT;
        else if (!pause_i) state_d = ST_RUN;
      end
      ST_HALT:    if (en_i && !pause_i) state_d = ST_WAIT;
      ST_WAIT:    state_d = ST_IDLE;
      ST_ABORT:   state_d = ST_ABORT;
      ST_BUFFCLR: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (soft_rst_i) state_d = ST_BUFFCLR;
  end

  assign cpl_evt_o   = (state_q == ST_RUN) && (state_d == ST_CPL);
  assign abort_evt_o = (state_q == ST_RUN) && (state_d == ST_ABORT);
  assign job_req_o   = (state_q == ST_RUN);
  assign state_o     = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      head_q  <= '0;
    end else begin
      state_q <= state_d;
      if (soft_rst_i)     head_q <= '0;
      else if (cpl_evt_o) head_q <= (head_q == sq_last_i) ? '0 : head_q + 1'b1;
    end
  end

  p_leave_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || pause_i) |=> state_q != ST_RUN);
  p_halt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && !en_i && !soft_rst_i) |=> state_q == ST_HALT);
  p_done_cpl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && en_i && !pause_i && !job_err_i && job_done_i && !soft_rst_i)
      |=> state_q == ST_CPL);
  p_abort_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ABORT && !soft_rst_i) |=> state_q == ST_ABORT);
  p_rst_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (state_q == ST_BUFFCLR && head_q == '0));
  p_clr_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUFFCLR && !soft_rst_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/dmaq_chan.sv
module dmaq_chan #(
  parameter int PTR_W = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        job_done_i,
  input  logic        job_err_i,
  output logic        job_req_o,
  output logic        irq_o
);
  import dmaq_pkg::*;

  localparam int PAD_W = DATA_W - PTR_W;

  logic [31:0]      sq_lo_q, sq_hi_q, cq_lo_q, cq_hi_q;
  logic [PTR_W-1:0] sq_last_q, cq_last_q, sq_tail_q, cq_head_q;
  logic             en_q, pause_q;
  logic [STS_W-1:0] sts_q, msk_q, sts_set, sts_clr;
  logic             soft_rst, cpl_evt, abort_evt;
  chan_state_e      state;

  assign soft_rst = wr_i && (off_i == OFF_CTL1) && wdata_i[0];

  dmaq_chan_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .pause_i     (pause_q),
    .soft_rst_i  (soft_rst),
    .sq_tail_i   (sq_tail_q),
    .sq_last_i   (sq_last_q),
    .job_done_i  (job_done_i),
    .job_err_i   (job_err_i),
    .state_o     (state),
    .job_req_o   (job_req_o),
    .cpl_evt_o   (cpl_evt),
    .abort_evt_o (abort_evt)
  );

  always_comb begin
    sts_set    = '0;
    sts_set[0] = cpl_evt;
    sts_set[1] = abort_evt;
    sts_clr    = (wr_i && off_i == OFF_ISTS) ? wdata_i[STS_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_lo_q   <= '0;
      sq_hi_q   <= '0;
      cq_lo_q   <= '0;
      cq_hi_q   <= '0;
      sq_last_q <= '1;
      cq_last_q <= '1;
      sq_tail_q <= '0;
      cq_head_q <= '0;
      en_q      <= 1'b0;
      pause_q   <= 1'b0;
      sts_q     <= '0;
      msk_q     <= '1;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr_i) begin
        unique case (off_i)
          OFF_SQ_LO:   sq_lo_q   <= wdata_i;
          OFF_SQ_HI:   sq_hi_q   <= wdata_i;
          OFF_SQ_LAST: sq_last_q <= wdata_i[PTR_W-1:0];
          OFF_SQ_TAIL: sq_tail_q <= wdata_i[PTR_W-1:0];
          OFF_CQ_LO:   cq_lo_q   <= wdata_i;
          OFF_CQ_HI:   cq_hi_q   <= wdata_i;
          OFF_CQ_LAST: cq_last_q <= wdata_i[PTR_W-1:0];
          OFF_CQ_HEAD: cq_head_q <= wdata_i[PTR_W-1:0];
          OFF_CTL0: begin
            en_q    <= wdata_i[0];
            pause_q <= wdata_i[4];
          end
          OFF_IMSK:    msk_q <= wdata_i[STS_W-1:0];
          default: ;
        endcase
      end
      if (soft_rst) begin
        sq_tail_q <= '0;
        cq_head_q <= '0;
      end
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_SQ_LO:   rdata_o = sq_lo_q;
      OFF_SQ_HI:   rdata_o = sq_hi_q;
      OFF_SQ_LAST: rdata_o = {{PAD_W{1'b0}}, sq_last_q};
      OFF_SQ_TAIL: rdata_o = {{PAD_W{1'b0}}, sq_tail_q};
      OFF_CQ_LO:   rdata_o = cq_lo_q;
      OFF_CQ_HI:   rdata_o = cq_hi_q;
      OFF_CQ_LAST: rdata_o = {{PAD_W{1'b0}}, cq_last_q};
      OFF_CQ_HEAD: rdata_o = {{PAD_W{1'b0}}, cq_head_q};
      OFF_CTL0:    rdata_o = {27'd0, pause_q, 3'd0, en_q};
      OFF_STATE:   rdata_o = {28'd0, state};
      OFF_ISTS:    rdata_o = {{(DATA_W-STS_W){1'b0}}, sts_q};
      OFF_IMSK:    rdata_o = {{(DATA_W-STS_W){1'b0}}, msk_q};
      default:     rdata_o = '0;
    endcase
  end

  assign irq_o = |(sts_q & ~msk_q);

  p_cpl_sts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_evt |=> sts_q[0]);
  p_abort_sts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_evt |=> sts_q[1]);
  p_rst_ptr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (sq_tail_q == '0 && cq_head_q == '0));
endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 14,
  parameter int PTR_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              mode_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] job_req_o,
  input  logic [NUM_CH-1:0] job_done_i,
  input  logic [NUM_CH-1:0] job_err_i
);
  localparam int CH_W = ADDR_W - 8;

  logic [CH_W-1:0] ch_idx;
  logic [7:0]      off;
  logic            ch_hit, mode_hit, mode_q, mode_wr;
  logic [31:0]     ch_rdata [NUM_CH];
  logic [31:0]     sel_rdata, rdata_q;

  dmaq_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i     (bus_addr_i),
    .ch_idx_o   (ch_idx),
    .off_o      (off),
    .ch_hit_o   (ch_hit),
    .mode_hit_o (mode_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic wr_sel;
    assign wr_sel = bus_req_i && bus_we_i && ch_hit && (ch_idx == CH_W'(g));
    dmaq_chan #(.PTR_W(PTR_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_sel),
      .off_i      (off),
      .wdata_i    (bus_wdata_i),
      .rdata_o    (ch_rdata[g]),
      .job_done_i (job_done_i[g]),
      .job_err_i  (job_err_i[g]),
      .job_req_o  (job_req_o[g]),
      .irq_o      (irq_o[g])
    );
  end

  always_comb begin
    sel_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_idx == CH_W'(i)) sel_rdata = ch_rdata[i];
  end

  assign mode_wr = bus_req_i && bus_we_i && mode_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (mode_wr) mode_q <= bus_wdata_i[0];
      if (bus_req_i && !bus_we_i)
        rdata_q <= mode_hit ? {31'd0, mode_q} : (ch_hit ? sel_rdata : '0);
    end
  end

  assign mode_o      = mode_q;
  assign bus_rdata_o = rdata_q;

  p_mode_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr |=> $stable(mode_o));
  p_miss_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && !ch_hit && !mode_hit) |=> bus_rdata_o == '0);
endmodule

// File: tb/dmaq_ctrl_bench.sv
module dmaq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic mode;
  logic [NUM_CH-1:0] irq, jreq, jdone = '0, jerr = '0;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic was_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaq_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PTR_W(10)) u_dmaq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mode_o(mode), .irq_o(irq), .job_req_o(jreq),
    .job_done_i(jdone), .job_err_i(jerr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one edge after a sampled read
  always @(posedge clk) begin
    was_rd = req && !we;
    #1;
    if (was_rd) begin
      if (exp_q.size() == 0) chk(32'hX, 32'h0, "scoreboard empty");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr_a(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask
  task automatic rd_a(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask
  task automatic wr(input int ch, input int off, input logic [31:0] d);
    wr_a(ADDR_W'(ch * 256 + off), d);
  endtask
  task automatic rd(input int ch, input int off, input logic [31:0] e, input string tag);
    rd_a(ADDR_W'(ch * 256 + off), e, tag);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic done_pulse(input int ch);
    jdone[ch] = 1'b1; @(negedge clk); jdone[ch] = 1'b0;
  endtask
  task automatic err_pulse(input int ch);
    jerr[ch] = 1'b1; @(negedge clk); jerr[ch] = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk({28'd0, irq}, 32'd0, "R10 irq after reset");
    chk({31'd0, mode}, 32'd0, "R11 mode after reset");
    rd(0, 'h08, 32'h3FF, "R1 sq depth reset");
    rd(0, 'h18, 32'h3FF, "R1 cq depth reset");
    rd(0, 'h44, 32'h1FFF, "R1 mask reset");
    rd(0, 'h30, 32'd0, "R1 state reset");
    rd(0, 'h20, 32'd0, "R1 ctrl0 reset");
    // R1 read/write, width
    wr(1, 'h00, 32'hDEADBEEF);
    wr(1, 'h14, 32'h12345678);
    wr(1, 'h18, 32'hFFFF);
    rd(1, 'h00, 32'hDEADBEEF, "R1 sq base lo");
    rd(1, 'h14, 32'h12345678, "R1 cq base hi");
    rd(1, 'h18, 32'h3FF, "R1 depth truncated");
    // R2 undefined offsets and channels
    wr(1, 'h28, 32'hFFFFFFFF);
    rd(1, 'h28, 32'd0, "R2 undefined offset");
    wr(5, 'h00, 32'hCAFEF00D);
    rd(5, 'h00, 32'd0, "R2 missing channel");
    rd(1, 'h00, 32'hDEADBEEF, "R2 no alias ch1");
    rd(0, 'h00, 32'd0, "R2 no alias ch0");
    wr(1, 'h30, 32'h5);
    rd(1, 'h30, 32'd0, "R2 state read-only");
    // R11 mode
    wr_a(ADDR_W'(16'h217C), 32'd1);
    chk({31'd0, mode}, 32'd1, "R11 mode_o");
    rd_a(ADDR_W'(16'h217C), 32'd1, "R11 mode readback");
    // R3 doorbell
    wr(0, 'h44, 32'd0);
    wr(0, 'h20, 32'd1);
    wr(0, 'h1C, 32'd5);
    wr(0, 'h0C, 32'd1);
    idle(1);
    chk({28'd0, jreq}, 32'd1, "R3 job_req in RUN");
    rd(0, 'h30, 32'd1, "R3 state RUN");
    // R4 completion
    done_pulse(0);
    rd(0, 'h30, 32'd2, "R4 state CPL");
    chk({31'd0, irq[0]}, 32'd1, "R10 irq on completion");
    rd(0, 'h40, 32'd1, "R9 status bit0");
    rd(0, 'h30, 32'd0, "R4 back to IDLE");
    wr(0, 'h40, 32'd1);
    chk({31'd0, irq[0]}, 32'd0, "R9 W1C clears irq");
    rd(0, 'h40, 32'd0, "R9 status cleared");
    // R10 mask
    wr(0, 'h44, 32'd1);
    wr(0, 'h0C, 32'd2);
    idle(1);
    done_pulse(0);
    idle(1);
    chk({31'd0, irq[0]}, 32'd0, "R10 masked irq");
    rd(0, 'h40, 32'd1, "R10 status under mask");
    wr(0, 'h44, 32'd0);
    chk({31'd0, irq[0]}, 32'd1, "R10 unmask raises irq");
    wr(0, 'h40, 32'd1);
    // R5 pause
    wr(0, 'h0C, 32'd3);
    idle(1);
    wr(0, 'h20, 32'h11);
    idle(1);
    rd(0, 'h30, 32'd3, "R5 state PAUSE");
    chk({28'd0, jreq}, 32'd0, "R5 no job_req in PAUSE");
    wr(0, 'h20, 32'd1);
    idle(1);
    rd(0, 'h30, 32'd1, "R5 resume RUN");
    // R6 halt / wait
    wr(0, 'h20, 32'd0);
    idle(1);
    rd(0, 'h30, 32'd4, "R6 state HALT");
    wr(0, 'h20, 32'd1);
    idle(1);
    rd(0, 'h30, 32'd6, "R6 state WAIT");
    idle(1);
    rd(0, 'h30, 32'd1, "R6 restart RUN");
    // R7 abort
    err_pulse(0);
    idle(1);
    rd(0, 'h30, 32'd5, "R7 state ABORT");
    chk({31'd0, irq[0]}, 32'd1, "R7 irq on abort");
    rd(0, 'h40, 32'd2, "R9 status bit1");
    idle(2);
    rd(0, 'h30, 32'd5, "R7 ABORT holds");
    wr(0, 'h40, 32'd2);
    // R8 reset
    wr(0, 'h24, 32'd1);
    rd(0, 'h30, 32'd7, "R8 state BUFFCLR");
    rd(0, 'h24, 32'd0, "R8 ctrl1 self-clears");
    rd(0, 'h0C, 32'd0, "R8 tail cleared");
    rd(0, 'h1C, 32'd0, "R8 cq head cleared");
    rd(0, 'h30, 32'd0, "R8 settles IDLE");
    chk({28'd0, jreq}, 32'd0, "R8 no work after reset");
    // R4 wrap and R12 independence on ch1
    wr(1, 'h08, 32'd1);
    wr(1, 'h44, 32'd0);
    wr(1, 'h20, 32'd1);
    wr(1, 'h0C, 32'd1);
    idle(1);
    done_pulse(1);
    wr(1, 'h0C, 32'd0);
    idle(1);
    chk({28'd0, jreq}, 32'd2, "R4 restart after tail wrap");
    done_pulse(1);
    idle(2);
    rd(1, 'h30, 32'd0, "R4 head wraps to 0");
    chk({28'd0, irq}, 32'd2, "R12 only ch1 irq");
    rd(0, 'h30, 32'd0, "R12 ch0 state untouched");
    idle(2);
    finished = 1'b1;
    if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'd0, "scoreboard leftovers");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule